// File: doc/BRIEF.md
# Loop Response Margin and Crossover Checker

This block screens a sampled loop frequency response for three shape faults in a single pass. Complex samples arrive one per valid cycle in signed fixed point (`FRAC_W` fraction bits), ordered from the dc bin upward. A target crossover bin is held on a side input. No arctangent or square root is used. Phase landmarks come only from the signs of the real and imaginary parts and from a comparison of their absolute values. Magnitudes are compared as `re²+im²` against 1.0 squared in the same scaling.

For each scan the block reports four things. It gives the −180° point (its bin and squared magnitude) and whether the gain margin there reaches 10 dB. It says whether the loop gain crosses unity more than once around the target. It says whether a −45° point, which marks flattening of the low-frequency gain, appears below the target. The first sample of a scan is the dc bin, and it is never evaluated. A sample marked last closes the scan. The results register at that clock edge, together with a one-cycle `done` pulse, and stay held until the next scan closes.

Top module: `loop_shape_check`

## Requirements
- R1: The first sample of each scan (bin 0, dc) takes part in no test, whatever its value.
- R2: The −180° point is the first bin ≥ 1 in which re < 0, im ≥ 0 and the previous non-dc bin had im < 0. `gm_bin` and `gm_mag2` (= re²+im²) report that bin, and later such bins are ignored. `gm_found` is 1 only if one occurred; otherwise `gm_bin` and `gm_mag2` read 0.
- R3: `gm_ok` is 1 when no −180° point occurred, or when its squared magnitude is ≤ floor(2^(2·FRAC_W)/10) (1677721 for FRAC_W = 12).
- R4: `multi_xover` is set if any bin b with 1 ≤ b < `target_bin` has re²+im² < 2^(2·FRAC_W).
- R5: `multi_xover` is also set if any bin b > `target_bin` has re²+im² > 2^(2·FRAC_W). The target bin itself is exempt from both tests.
- R6: The −45° point is the first bin ≥ 1 with re > 0, im < 0 and |re| > |im| strictly. `m45_found` and `m45_bin` report it (0 when absent).
- R7: `flatten` is 1 when a −45° point exists at a bin below `target_bin`.
- R8: `pass` equals `gm_ok` AND NOT `multi_xover` AND NOT `flatten`.
- R9: When a sample with `in_last` is accepted, every result and a one-cycle `done` appear after that same clock edge. Results hold until the next scan ends, and the following sample starts a new scan at bin 0.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_re | input | DATA_W (16) | Real part, signed, FRAC_W fraction bits |
| in_im | input | DATA_W (16) | Imaginary part, signed, FRAC_W fraction bits |
| in_last | input | 1 | Sample is the final bin of the scan |
| target_bin | input | BIN_W (10) | Target crossover bin, held during a scan |
| done | output | 1 | One-cycle pulse, results updated |
| pass | output | 1 | All three tests passed |
| gm_ok | output | 1 | Gain margin met or no −180° point |
| multi_xover | output | 1 | Extra unity crossing detected |
| flatten | output | 1 | −45° point below target |
| gm_found | output | 1 | A −180° point was seen |
| gm_bin | output | BIN_W (10) | Bin of the −180° point |
| gm_mag2 | output | 2·DATA_W (32) | Squared magnitude at the −180° point |
| m45_found | output | 1 | A −45° point was seen |
| m45_bin | output | BIN_W (10) | Bin of the −45° point |

## Verification
A wrong bin counter or a missed dc skip moves every reported bin and shows on `gm_bin` or `m45_bin` in the `done` cycle of the first affected scan. A sticky "first point" flag that is not cleared between scans shows up in the next scan, which returns a stale or zero bin. A comparator that is off by one or uses the wrong sign is exposed by samples sitting just inside the 10 dB limit, by an exact |re| = |im| tie, and by a sample at the target bin that would fail either unity test. Every error is visible at the first `done` pulse after the faulty sample.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Per-sample phase classification produced from signs and magnitudes only
  typedef struct packed {
    logic m180;    // -180 deg crossing candidate
    logic m45;     // -45 deg landmark candidate
    logic im_neg;  // imaginary part below zero
  } lsc_cls_t;
endpackage

// File: rtl/lsc_mag2.sv
module lsc_mag2 #(
  parameter int DATA_W = 16,
  localparam int MAG_W = 2 * DATA_W
) (
  input  logic signed [DATA_W-1:0] re,
  input  logic signed [DATA_W-1:0] im,
  output logic        [MAG_W-1:0]  mag2
);
  logic signed [MAG_W-1:0] re_x, im_x, sq_re, sq_im;

  always_comb begin
    re_x  = {{DATA_W{re[DATA_W-1]}}, re};
    im_x  = {{DATA_W{im[DATA_W-1]}}, im};
    sq_re = re_x * re_x;
    sq_im = im_x * im_x;
    mag2  = $unsigned(sq_re) + $unsigned(sq_im);
  end
endmodule

// File: rtl/lsc_phase_cls.sv
module lsc_phase_cls
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] re,
  input  logic signed [DATA_W-1:0] im,
  input  logic                     prev_im_neg,
  output lsc_cls_t                 cls
);
  logic [DATA_W:0] abs_re, abs_im;
  logic signed [DATA_W:0] re_x, im_x;

  always_comb begin
    re_x   = {re[DATA_W-1], re};
    im_x   = {im[DATA_W-1], im};
    abs_re = re[DATA_W-1] ? $unsigned(-re_x) : $unsigned(re_x);
    abs_im = im[DATA_W-1] ? $unsigned(-im_x) : $unsigned(im_x);
    cls.im_neg = im[DATA_W-1];
    cls.m180   = re[DATA_W-1] && !im[DATA_W-1] && prev_im_neg;
    cls.m45    = !re[DATA_W-1] && (re != '0) && im[DATA_W-1] && (abs_re > abs_im);
  end
endmodule

// File: rtl/loop_shape_check.sv
module loop_shape_check
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12,
  parameter int BIN_W  = 10,
  localparam int MAG_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  input  logic                     in_last,
  input  logic [BIN_W-1:0]         target_bin,
  output logic                     done,
  output logic                     pass,
  output logic                     gm_ok,
  output logic                     multi_xover,
  output logic                     flatten,
  output logic                     gm_found,
  output logic [BIN_W-1:0]         gm_bin,
  output logic [MAG_W-1:0]         gm_mag2,
  output logic                     m45_found,
  output logic [BIN_W-1:0]         m45_bin
);
  localparam logic [MAG_W-1:0] UNITY_SQ = MAG_W'(1) << (2 * FRAC_W);
  localparam logic [MAG_W-1:0] GM_LIMIT = UNITY_SQ / MAG_W'(10);

  // scan state
  logic [BIN_W-1:0] bin_q, bin_n;
  logic             prev_neg_q, prev_neg_n;
  logic             gm_hit_q, gm_hit_n, m45_hit_q, m45_hit_n, multi_q, multi_n;
  logic [BIN_W-1:0] gm_bin_q, gm_bin_n, m45_bin_q, m45_bin_n;
  logic [MAG_W-1:0] gm_mag_q, gm_mag_n;
  // result state
  logic             done_n, pass_n, gm_ok_n, multi_res_n, flat_n;
  logic             gm_found_n, m45_found_n;
  logic [BIN_W-1:0] gm_bin_res_n, m45_bin_res_n;
  logic [MAG_W-1:0] gm_mag_res_n;

  logic [MAG_W-1:0] smp_mag2;
  lsc_cls_t         smp_cls;

  lsc_mag2 #(.DATA_W(DATA_W)) i_mag2 (
    .re(in_re), .im(in_im), .mag2(smp_mag2)
  );

  lsc_phase_cls #(.DATA_W(DATA_W)) i_cls (
    .re(in_re), .im(in_im), .prev_im_neg(prev_neg_q), .cls(smp_cls)
  );

  always_comb begin
    bin_n       = bin_q;
    prev_neg_n  = prev_neg_q;
    gm_hit_n    = gm_hit_q;
    gm_bin_n    = gm_bin_q;
    gm_mag_n    = gm_mag_q;
    m45_hit_n   = m45_hit_q;
    m45_bin_n   = m45_bin_q;
    multi_n     = multi_q;
    done_n      = 1'b0;
    pass_n      = pass;
    gm_ok_n     = gm_ok;
    multi_res_n = multi_xover;
    flat_n      = flatten;
    gm_found_n  = gm_found;
    gm_bin_res_n  = gm_bin;
    gm_mag_res_n  = gm_mag2;
    m45_found_n   = m45_found;
    m45_bin_res_n = m45_bin;

    if (in_valid) begin
      bin_n = bin_q + 1'b1;
      if (bin_q == '0) begin
        prev_neg_n = 1'b0;          // dc bin: no test
      end else begin
        prev_neg_n = smp_cls.im_neg;
        if (smp_cls.m180 && !gm_hit_q) begin
          gm_hit_n = 1'b1;
          gm_bin_n = bin_q;
          gm_mag_n = smp_mag2;
        end
        if (smp_cls.m45 && !m45_hit_q) begin
          m45_hit_n = 1'b1;
          m45_bin_n = bin_q;
        end
        if ((bin_q < target_bin) && (smp_mag2 < UNITY_SQ)) multi_n = 1'b1;
        if ((bin_q > target_bin) && (smp_mag2 > UNITY_SQ)) multi_n = 1'b1;
      end

      if (in_last) begin
        done_n        = 1'b1;
        gm_ok_n       = !gm_hit_n || (gm_mag_n <= GM_LIMIT);
        multi_res_n   = multi_n;
        flat_n        = m45_hit_n && (m45_bin_n < target_bin);
        pass_n        = gm_ok_n && !multi_n && !flat_n;
        gm_found_n    = gm_hit_n;
        gm_bin_res_n  = gm_bin_n;
        gm_mag_res_n  = gm_mag_n;
        m45_found_n   = m45_hit_n;
        m45_bin_res_n = m45_bin_n;
        bin_n      = '0;
        prev_neg_n = 1'b0;
        gm_hit_n   = 1'b0;
        gm_bin_n   = '0;
        gm_mag_n   = '0;
        m45_hit_n  = 1'b0;
        m45_bin_n  = '0;
        multi_n    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q      <= '0;
      prev_neg_q <= 1'b0;
      gm_hit_q   <= 1'b0;
      gm_bin_q   <= '0;
      gm_mag_q   <= '0;
      m45_hit_q  <= 1'b0;
      m45_bin_q  <= '0;
      multi_q    <= 1'b0;
    end else if (in_valid) begin
      bin_q      <= bin_n;
      prev_neg_q <= prev_neg_n;
      gm_hit_q   <= gm_hit_n;
      gm_bin_q   <= gm_bin_n;
      gm_mag_q   <= gm_mag_n;
      m45_hit_q  <= m45_hit_n;
      m45_bin_q  <= m45_bin_n;
      multi_q    <= multi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      pass        <= 1'b0;
      gm_ok       <= 1'b0;
      multi_xover <= 1'b0;
      flatten     <= 1'b0;
      gm_found    <= 1'b0;
      gm_bin      <= '0;
      gm_mag2     <= '0;
      m45_found   <= 1'b0;
      m45_bin     <= '0;
    end else begin
      done        <= done_n;
      pass        <= pass_n;
      gm_ok       <= gm_ok_n;
      multi_xover <= multi_res_n;
      flatten     <= flat_n;
      gm_found    <= gm_found_n;
      gm_bin      <= gm_bin_res_n;
      gm_mag2     <= gm_mag_res_n;
      m45_found   <= m45_found_n;
      m45_bin     <= m45_bin_res_n;
    end
  end

  // R9: done follows an accepted last sample, and only that
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> done);
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));
  // R9: results are held between done pulses
  p_results_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pass) && $stable(gm_bin) && $stable(m45_bin) && $stable(gm_mag2)));
  // R1/R2: a reported -180 point never sits on the dc bin
  p_gm_not_dc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gm_found |-> (gm_bin != '0));
  // R3: a failed margin implies a -180 point was found
  p_gm_fail_found_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gm_ok) |-> gm_found);
  // R7: flattening needs a -45 point
  p_flat_needs_m45_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flatten |-> (m45_found && (m45_bin != '0)));
  // R8: pass excludes every fault flag
  p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (gm_ok && !multi_xover && !flatten));
endmodule

// File: tb/test_loop_shape_check.sv
module test_loop_shape_check;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 12;
  localparam int BIN_W  = 10;
  localparam int MAG_W  = 2 * DATA_W;
  localparam int NS = 10;
  localparam int NB = 6;

  // streams: bins 0..5, target bin 3 (Q4.12, 1.0 = 4096)
  localparam int SRE [NS][NB] = '{
    '{0, -100, -1000, -3000, -1200,  -800},   // A baseline pass
    '{0, -100, -1000, -3000, -1200, -1300},   // B margin fails (R3)
    '{0, -100, -1000, -3000, -1200, -1295},   // C margin just met (R3)
    '{0, -100, -1000, -3000, -1200,  -800},   // D dip below unity (R4)
    '{0, -100, -1000, -3000, -4000,  -800},   // E rise above unity (R5)
    '{0, 5000, -1000, -3000, -1200,  -800},   // F -45 below target (R6, R7)
    '{0, -100, -1000, -3000,  1000,  -800},   // G -45 above target (R6, R7)
    '{0, -100, -1000, -3000, -1200,  -800},   // H no -180 point (R2, R3)
    '{5000, -100, -1000, -3000, -1200, -800}, // I dc would flag (R1)
    '{0, 4000, -1000, -3000, -1200,  -800}    // K |re|==|im| tie (R6)
  };
  localparam int SIM [NS][NB] = '{
    '{0, -8000, -6000, -2800,  -500,  300},
    '{0, -8000, -6000, -2800,  -500,  200},
    '{0, -8000, -6000, -2800,  -500,   26},
    '{0, -8000, -3000, -2800,  -500,  300},
    '{0, -8000, -6000, -2800, -1000,  300},
    '{0, -1000, -6000, -2800,  -500,  300},
    '{0, -8000, -6000, -2800,  -500,  300},
    '{0, -8000, -6000, -2800,  -500, -300},
    '{-100, -8000, -6000, -2800, -500, 300},
    '{0, -4000, -6000, -2800,  -500,  300}
  };
  localparam int E_GMOK [NS] = '{1,0,1,1,1,1,1,1,1,1};
  localparam int E_MULT [NS] = '{0,0,0,1,1,0,0,0,0,0};
  localparam int E_FLAT [NS] = '{0,0,0,0,0,1,0,0,0,0};
  localparam int E_GMF  [NS] = '{1,1,1,1,1,1,1,0,1,1};
  localparam int E_GMB  [NS] = '{5,5,5,5,5,5,5,0,5,5};
  localparam int E_MAG  [NS] = '{730000,1730000,1677701,730000,730000,730000,730000,0,730000,730000};
  localparam int E_M45F [NS] = '{0,0,0,0,0,1,1,0,0,0};
  localparam int E_M45B [NS] = '{0,0,0,0,0,1,4,0,0,0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_re = '0;
  logic signed [DATA_W-1:0] in_im = '0;
  logic in_last = 1'b0;
  logic [BIN_W-1:0] target_bin = 10'd3;
  logic done, pass, gm_ok, multi_xover, flatten, gm_found, m45_found;
  logic [BIN_W-1:0] gm_bin, m45_bin;
  logic [MAG_W-1:0] gm_mag2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  loop_shape_check #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .BIN_W(BIN_W)) i_loop_shape_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_last(in_last), .target_bin(target_bin), .done(done), .pass(pass),
    .gm_ok(gm_ok), .multi_xover(multi_xover), .flatten(flatten),
    .gm_found(gm_found), .gm_bin(gm_bin), .gm_mag2(gm_mag2),
    .m45_found(m45_found), .m45_bin(m45_bin)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic send(input int re, input int im, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_re    = DATA_W'(re);
    in_im    = DATA_W'(im);
    in_last  = last;
  endtask

  // after the last sample: drop valid, then sample in the done cycle
  task automatic finish_scan();
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic check_all(input string tag, input int gmok, input int mult, input int flat,
                           input int gmf, input int gmb, input int mag, input int m45f, input int m45b);
    chk({tag, " R9 done"}, done, 1);
    chk({tag, " R3 gm_ok"}, gm_ok, gmok);
    chk({tag, " R4/R5 multi_xover"}, multi_xover, mult);
    chk({tag, " R7 flatten"}, flatten, flat);
    chk({tag, " R2 gm_found"}, gm_found, gmf);
    chk({tag, " R2 gm_bin"}, gm_bin, gmb);
    chk({tag, " R2 gm_mag2"}, gm_mag2, mag);
    chk({tag, " R6 m45_found"}, m45_found, m45f);
    chk({tag, " R6 m45_bin"}, m45_bin, m45b);
    chk({tag, " R8 pass"}, pass, (gmok == 1 && mult == 0 && flat == 0) ? 1 : 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 done", done, 0);
    chk("R10 pass", pass, 0);
    chk("R10 gm_ok", gm_ok, 0);
    chk("R10 gm_bin", gm_bin, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < NB; b++) send(SRE[s][b], SIM[s][b], b == NB - 1);
      finish_scan();
      check_all($sformatf("stream%0d", s), E_GMOK[s], E_MULT[s], E_FLAT[s],
                E_GMF[s], E_GMB[s], E_MAG[s], E_M45F[s], E_M45B[s]);
    end

    // R9 done is a single cycle and results hold
    @(negedge clk);
    chk("R9 done drops", done, 0);
    chk("R9 gm_bin held", gm_bin, 5);
    chk("R9 pass held", pass, 1);

    // R2 only the first -180 crossing counts
    send(0, 0, 0); send(-100, -8000, 0); send(-1000, -6000, 0); send(-3000, -2800, 0);
    send(-1200, 200, 0); send(-900, -100, 0); send(-500, 100, 1);
    finish_scan();
    chk("R2 first crossing bin", gm_bin, 4);
    chk("R2 first crossing mag2", gm_mag2, 1480000);

    // R4 target moved up: bin 4 now below target and under unity; bin 5 exempt
    target_bin = 10'd5;
    for (int b = 0; b < NB; b++) send(SRE[0][b], SIM[0][b], b == NB - 1);
    finish_scan();
    chk("R4 multi below moved target", multi_xover, 1);
    chk("R8 pass with multi", pass, 0);
    target_bin = 10'd3;

    // R1 dc-only scan: nothing evaluated
    send(5000, -100, 1);
    finish_scan();
    chk("R1 dc-only done", done, 1);
    chk("R1 dc-only m45_found", m45_found, 0);
    chk("R1 dc-only gm_found", gm_found, 0);
    chk("R1 dc-only pass", pass, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule